// File: doc/BRIEF.md
# Unaligned Load Data Aligner

This block builds the register value for a load whose byte address is not a multiple of four. The memory side supplies two aligned words: the word at the base address (the byte address with its two low bits cleared) and the word at base+4. The block takes those two words, the two low address bits, an endianness strap and a load-kind code. It returns the addressed value, narrowed and extended when the access is a halfword.

A single funnel shifter serves both byte orders. In little-endian mode the pair is joined as {upper word, lower word} and shifted right by eight bits per byte of offset. In big-endian mode the operand order and the shift direction are both swapped. A halfword load always takes bits [15:0] of the funnel result and then either zero-fills or sign-fills the upper half. A request accepted on one clock edge shows up on the registered output at that same edge, with a one-cycle valid pulse.

Top module: `unaligned_load_align`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), `out_valid` and `out_data` become 0.
- R2: `out_valid` after an edge equals `in_valid` sampled at that edge. A request gives a one-cycle pulse, and back-to-back requests give one result per cycle.
- R3: With `big_endian`=0, memory byte k of a word sits at bits [8k+7:8k]. A word load (`load_kind`=00) at byte offset `addr_lo`=a returns memory bytes a..a+3, with byte a in bits [7:0]. Bytes 4..7 come from `hi_word`.
- R4: With `big_endian`=1, memory byte k of a word sits at bits [31-8k:24-8k]. A word load at offset a returns memory bytes a..a+3, with byte a in bits [31:24].
- R5: When `addr_lo`=00, a word load returns `lo_word` unchanged in either byte order.
- R6: With `load_kind`=01 (halfword, zero-extended), the result holds bits [15:0] of the R3/R4 word in bits [15:0], and bits [31:16] are 0.
- R7: With `load_kind`=10 (halfword, sign-extended), the result holds bits [15:0] of the R3/R4 word, and bit 15 is copied into bits [31:16].
- R8: `load_kind`=11 is handled exactly like a word load.
- R9: On an edge where `in_valid` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| lo_word | input | 32 | Memory word at the aligned base address |
| hi_word | input | 32 | Memory word at base+4 |
| addr_lo | input | 2 | Low two bits of the byte address |
| big_endian | input | 1 | Byte-order strap, 1 = big-endian |
| load_kind | input | 2 | 00 word, 01 half zero-ext, 10 half sign-ext, 11 word |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_data | output | 32 | Aligned and extended load result |

## Verification
The checker tests several properties on every cycle. It checks the one-cycle valid relation and that data holds on idle cycles. It checks that halfword results have a zero or sign-copied upper half, and that aligned word loads return the lower word unchanged. Byte placement for nonzero offsets cannot be expressed that way, so the bench covers it. The bench compares results from both byte orders at every offset against a byte-by-byte reference model, and it also covers reserved-kind handling and the reset state.

// File: rtl/ula_pkg.sv
package ula_pkg;
    typedef enum logic [1:0] {
        LK_WORD   = 2'b00,
        LK_HALF_U = 2'b01,
        LK_HALF_S = 2'b10,
        LK_RSVD   = 2'b11
    } load_kind_e;
endpackage

// File: rtl/ula_funnel.sv
// Two-word funnel shifter shared by both byte orders.
module ula_funnel #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              big_endian,
    output logic [DATA_W-1:0] word_out
);
    localparam int SH_W = $clog2(2 * DATA_W);

    logic [2*DATA_W-1:0] pair;
    logic [2*DATA_W-1:0] moved;
    logic [SH_W-1:0]     shamt;

    always_comb begin
        shamt = SH_W'(ofs) * SH_W'(LANE_W);
        if (big_endian) begin
            // lower-address word on the left, move toward the top
            pair     = {lo_word, hi_word};
            moved    = pair << shamt;
            word_out = DATA_W'(moved >> DATA_W);
        end else begin
            // lower-address word on the right, move toward the bottom
            pair     = {hi_word, lo_word};
            moved    = pair >> shamt;
            word_out = DATA_W'(moved);
        end
    end
endmodule

// File: rtl/ula_narrow.sv
// Width selection and extension on the funnel result.
module ula_narrow #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0]    word_in,
    input  ula_pkg::load_kind_e  kind,
    output logic [DATA_W-1:0]    data_out
);
    always_comb begin
        unique case (kind)
            ula_pkg::LK_HALF_U: data_out = {{HALF_W{1'b0}}, word_in[HALF_W-1:0]};
            ula_pkg::LK_HALF_S: data_out = {{HALF_W{word_in[HALF_W-1]}}, word_in[HALF_W-1:0]};
            default:            data_out = word_in;
        endcase
    end
endmodule

// File: rtl/unaligned_load_align.sv
module unaligned_load_align #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] lo_word,
    input  logic [DATA_W-1:0] hi_word,
    input  logic [OFS_W-1:0]  addr_lo,
    input  logic              big_endian,
    input  logic [1:0]        load_kind,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t state_d, state_q;
    logic [DATA_W-1:0] funnel_w;
    logic [DATA_W-1:0] narrow_w;

    ula_funnel #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_funnel (
        .lo_word    (lo_word),
        .hi_word    (hi_word),
        .ofs        (addr_lo),
        .big_endian (big_endian),
        .word_out   (funnel_w)
    );

    ula_narrow #(.DATA_W(DATA_W)) u_narrow (
        .word_in  (funnel_w),
        .kind     (ula_pkg::load_kind_e'(load_kind)),
        .data_out (narrow_w)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.data = narrow_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign out_data  = state_q.data;
endmodule

// File: rtl/ula_checker.sv
module ula_checker #(
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2,
    localparam int HALF_W = DATA_W / 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] lo_word,
    input logic [OFS_W-1:0]  addr_lo,
    input logic [1:0]        load_kind,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_aligned_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && addr_lo == '0 && (load_kind == 2'b00 || load_kind == 2'b11))
        |=> out_data == $past(lo_word));

    assert_half_zero_fill_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && load_kind == 2'b01) |=> out_data[DATA_W-1:HALF_W] == '0);

    assert_half_sign_fill_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && load_kind == 2'b10)
        |=> out_data[DATA_W-1:HALF_W] == {HALF_W{out_data[HALF_W-1]}});

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
endmodule

bind unaligned_load_align ula_checker #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .lo_word   (lo_word),
    .addr_lo   (addr_lo),
    .load_kind (load_kind),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/unaligned_load_align_bench.sv
module unaligned_load_align_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] lo_word = '0;
    logic [31:0] hi_word = '0;
    logic [1:0]  addr_lo = '0;
    logic        big_endian = 1'b0;
    logic [1:0]  load_kind = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unaligned_load_align u_unaligned_load_align (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lo_word(lo_word),
        .hi_word(hi_word), .addr_lo(addr_lo), .big_endian(big_endian),
        .load_kind(load_kind), .out_valid(out_valid), .out_data(out_data)
    );

    // Byte-level reference built from the byte-placement requirements.
    function automatic logic [31:0] ref_load(input logic [31:0] lo, input logic [31:0] hi,
                                             input logic [1:0] a, input logic be,
                                             input logic [1:0] k);
        logic [7:0]  mem [8];
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            mem[i]   = be ? lo[31-8*i -: 8] : lo[8*i +: 8];
            mem[i+4] = be ? hi[31-8*i -: 8] : hi[8*i +: 8];
        end
        for (int i = 0; i < 4; i++) begin
            if (be) w[31-8*i -: 8] = mem[int'(a)+i];
            else    w[8*i +: 8]    = mem[int'(a)+i];
        end
        case (k)
            2'b01:   return {16'h0000, w[15:0]};
            2'b10:   return {{16{w[15]}}, w[15:0]};
            default: return w;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] a, input logic be, input logic [1:0] k);
        if (k == 2'b01) return "R6";
        if (k == 2'b10) return "R7";
        if (k == 2'b11) return "R8";
        if (a == 2'b00) return "R5";
        return be ? "R4" : "R3";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] lo, input logic [31:0] hi, input logic [1:0] a,
                         input logic be, input logic [1:0] k);
        in_valid = 1'b1; lo_word = lo; hi_word = hi; addr_lo = a; big_endian = be; load_kind = k;
        @(negedge clk);
        check("R2", {31'd0, out_valid}, 32'd1);
        check(tag_of(a, be, k), out_data, ref_load(lo, hi, a, be, k));
    endtask

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", out_data, 32'd0);
        rst = 1'b0;

        // directed corners
        for (int be = 0; be < 2; be++) begin
            for (int a = 0; a < 4; a++) begin
                issue(32'h33221100, 32'h77665544, 2'(a), 1'(be), 2'b00);
            end
        end
        issue(32'hCAFEF00D, 32'h12345678, 2'b00, 1'b0, 2'b00); // R5 LE
        issue(32'hCAFEF00D, 32'h12345678, 2'b00, 1'b1, 2'b00); // R5 BE
        issue(32'h80FF0000, 32'h00000000, 2'b10, 1'b0, 2'b10); // R7 negative half
        issue(32'h80FF0000, 32'h00000000, 2'b10, 1'b0, 2'b01); // R6 same data
        issue(32'h0000FF80, 32'h00000000, 2'b00, 1'b1, 2'b10); // R7 BE
        issue(32'h11223344, 32'h55667788, 2'b11, 1'b1, 2'b11); // R8
        issue(32'h11223344, 32'h55667788, 2'b01, 1'b0, 2'b11); // R8

        // idle cycles: no pulse, data held (R2, R9)
        held = out_data;
        in_valid = 1'b0; lo_word = 32'hDEADBEEF; hi_word = 32'hFEEDFACE; load_kind = 2'b10;
        repeat (2) begin
            @(negedge clk);
            check("R2", {31'd0, out_valid}, 32'd0);
            check("R9", out_data, held);
        end

        // random stream
        for (int n = 0; n < 400; n++) begin
            issue($urandom, $urandom, 2'($urandom), 1'($urandom), 2'($urandom));
            if (($urandom % 8) == 0) begin
                held = out_data;
                in_valid = 1'b0; lo_word = $urandom;
                @(negedge clk);
                check("R9", out_data, held);
            end
        end

        // reset again from a busy state
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R1", {31'd0, out_valid}, 32'd0);
        check("R1", out_data, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule